// File: doc/BRIEF.md
# Nested Sub-Register Integer File

This block holds sixteen 64-bit integer registers. Every register can be reached through nested views of 8, 16, 32 or 64 bits, always counted up from bit 0. On the first four registers, bits 15:8 can also be reached as a separate byte. Two combinational read ports each pick a register, a view size and a high-byte flag. A read returns the chosen view zero-extended to 64 bits.

A single synchronous write port follows the partial-write rules of a common 64-bit machine:
- A 64-bit write replaces the whole register.
- A 32-bit write stores the low half and clears bits 63:32.
- An 8-bit or 16-bit write changes only its own lanes.

The write port can also widen a narrow source into a wider destination, filling with zeros or with copies of the source's top bit. A pair that cannot be encoded is dropped, and an error pulse is raised for that write.

The block sits in an execution datapath. The decoder supplies the index, size and extension fields directly, and the operands are read in the same cycle.

Top module: `nested_regfile`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all sixteen registers to zero and clears ext_err.
- R2: A write with wr_size 3 (64 bits) and wr_ext 0 stores all of wr_data. Both read ports can return different registers in the same cycle.
- R3: Read size codes are 0 = bits 7:0, 1 = bits 15:0, 2 = bits 31:0 and 3 = bits 63:0. The read data is the view zero-extended to 64 bits.
- R4: With size 0 and the high-byte flag set, indices 0 to 3 address bits 15:8, for both reads and plain writes. For indices 4 to 15 the flag is ignored and bits 7:0 are used.
- R5: A plain write with wr_size 2 stores wr_data[31:0] and forces bits 63:32 to zero.
- R6: A plain write with wr_size 0 or 1 changes only the addressed 8 or 16 bits. All other bits keep their value.
- R7: wr_ext 1 (zero mode) takes the low wr_src_size bits of wr_data and fills the rest with zeros. The result is written at wr_size using the R5/R6 lane rules.
- R8: wr_ext 2 (sign mode) does the same as R7 but fills with copies of the source's top bit. Source 32 to destination 64 is allowed in this mode.
- R9: An extension write is illegal, leaves the register unchanged and drives ext_err high in the cycle after the write, for that one cycle only, when any of these holds:
  - the source size is not smaller than the destination size;
  - the mode is zero mode with source 32 and destination 64;
  - wr_ext is 3.
- R10: A read of the register being written in the same cycle returns the old value. The new value is readable after the clock edge.
- R11: With wr_en low, no register changes and ext_err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Destination size code |
| wr_hi | input | 1 | High-byte select for plain byte writes |
| wr_ext | input | 2 | 0 plain, 1 zero-extend, 2 sign-extend, 3 reserved |
| wr_src_size | input | 2 | Source size code for extension writes |
| wr_data | input | 64 | Write data |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 64 | Read port 1 data |
| ext_err | output | 1 | One-cycle pulse after an illegal extension write |

## Verification
A read and a write of the same register can land in the same cycle. The bench provokes this by raising a 64-bit write to one register while a read port points at that register. It then samples the read data before the edge, expecting the old contents, and again after the edge, expecting the new word. The other port reads a different register at the same time, and its result is judged against its own unchanged contents.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  typedef enum logic [1:0] {
    VSZ_B = 2'd0,
    VSZ_W = 2'd1,
    VSZ_D = 2'd2,
    VSZ_Q = 2'd3
  } vsize_e;

  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_ZERO = 2'd1,
    FILL_SIGN = 2'd2,
    FILL_RSVD = 2'd3
  } fill_e;
endpackage

// File: rtl/nrf_write_merge.sv
module nrf_write_merge
  import nrf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IDXW    = 4,
  parameter int HB_REGS = 4
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      size,
  input  logic            hi,
  input  logic [1:0]      ext,
  input  logic [1:0]      src_size,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] new_word,
  output logic            illegal
);
  localparam logic [IDXW-1:0] HB_LIM = IDXW'(HB_REGS);

  vsize_e dst_sz, src_sz;
  fill_e  mode;
  logic [XLEN-1:0] eff;
  logic            hi_ok;

  assign dst_sz = vsize_e'(size);
  assign src_sz = vsize_e'(src_size);
  assign mode   = fill_e'(ext);

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                            input vsize_e sz,
                                            input logic sgn);
    logic [XLEN-1:0] r;
    case (sz)
      VSZ_B:   r = {{(XLEN-8){sgn & v[7]}}, v[7:0]};
      VSZ_W:   r = {{(XLEN-16){sgn & v[15]}}, v[15:0]};
      VSZ_D:   r = {{(XLEN-32){sgn & v[31]}}, v[31:0]};
      default: r = v;
    endcase
    return r;
  endfunction

  always_comb begin
    illegal = 1'b0;
    hi_ok   = 1'b0;
    eff     = data;
    if (mode == FILL_NONE) begin
      hi_ok = hi && (dst_sz == VSZ_B) && (idx < HB_LIM);
    end else begin
      illegal = (mode == FILL_RSVD) || (src_sz >= dst_sz) ||
                (mode == FILL_ZERO && src_sz == VSZ_D);
      eff     = widen(data, src_sz, mode == FILL_SIGN);
    end
  end

  always_comb begin
    case (dst_sz)
      VSZ_B:   new_word = hi_ok ? {old_word[XLEN-1:16], eff[7:0], old_word[7:0]}
                                : {old_word[XLEN-1:8], eff[7:0]};
      VSZ_W:   new_word = {old_word[XLEN-1:16], eff[15:0]};
      VSZ_D:   new_word = {{(XLEN-32){1'b0}}, eff[31:0]};
      default: new_word = eff;
    endcase
    if (illegal) new_word = old_word;
  end
endmodule

// File: rtl/nrf_read_view.sv
module nrf_read_view
  import nrf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IDXW    = 4,
  parameter int HB_REGS = 4
) (
  input  logic [XLEN-1:0] word,
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] view
);
  localparam logic [IDXW-1:0] HB_LIM = IDXW'(HB_REGS);

  always_comb begin
    case (vsize_e'(size))
      VSZ_B:   view = (hi && idx < HB_LIM) ? {{(XLEN-8){1'b0}}, word[15:8]}
                                           : {{(XLEN-8){1'b0}}, word[7:0]};
      VSZ_W:   view = {{(XLEN-16){1'b0}}, word[15:0]};
      VSZ_D:   view = {{(XLEN-32){1'b0}}, word[31:0]};
      default: view = word;
    endcase
  end
endmodule

// File: rtl/nested_regfile.sv
module nested_regfile
  import nrf_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int XLEN    = 64,
  parameter int HB_REGS = 4,
  parameter int IDXW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_hi,
  input  logic [1:0]      wr_ext,
  input  logic [1:0]      wr_src_size,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IDXW-1:0] rd0_idx,
  input  logic [1:0]      rd0_size,
  input  logic            rd0_hi,
  output logic [XLEN-1:0] rd0_data,
  input  logic [IDXW-1:0] rd1_idx,
  input  logic [1:0]      rd1_size,
  input  logic            rd1_hi,
  output logic [XLEN-1:0] rd1_data,
  output logic            ext_err
);
  localparam int NRD = 2;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] old_word, new_word;
  logic            illegal;

  assign old_word = regs[wr_idx];

  nrf_write_merge #(.XLEN(XLEN), .IDXW(IDXW), .HB_REGS(HB_REGS)) u_merge (
    .old_word (old_word),
    .idx      (wr_idx),
    .size     (wr_size),
    .hi       (wr_hi),
    .ext      (wr_ext),
    .src_size (wr_src_size),
    .data     (wr_data),
    .new_word (new_word),
    .illegal  (illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      ext_err <= 1'b0;
    end else begin
      if (wr_en) regs[wr_idx] <= new_word;
      ext_err <= wr_en && illegal;
    end
  end

  logic [IDXW-1:0] rp_idx  [NRD];
  logic [1:0]      rp_size [NRD];
  logic            rp_hi   [NRD];
  logic [XLEN-1:0] rp_data [NRD];

  assign rp_idx[0]  = rd0_idx;
  assign rp_size[0] = rd0_size;
  assign rp_hi[0]   = rd0_hi;
  assign rp_idx[1]  = rd1_idx;
  assign rp_size[1] = rd1_size;
  assign rp_hi[1]   = rd1_hi;
  assign rd0_data   = rp_data[0];
  assign rd1_data   = rp_data[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    nrf_read_view #(.XLEN(XLEN), .IDXW(IDXW), .HB_REGS(HB_REGS)) u_view (
      .word (regs[rp_idx[p]]),
      .idx  (rp_idx[p]),
      .size (rp_size[p]),
      .hi   (rp_hi[p]),
      .view (rp_data[p])
    );
  end

  // R9
  err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    ext_err |-> $past(wr_en));

  // R9
  illegal_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && illegal) |=> regs[$past(wr_idx)] == $past(old_word));

  // R5
  dword_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !illegal && wr_size == VSZ_D) |=> regs[$past(wr_idx)][XLEN-1:32] == '0);

  // R6
  byte_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ext == FILL_NONE && wr_size == VSZ_B)
      |=> regs[$past(wr_idx)][XLEN-1:16] == $past(old_word[XLEN-1:16]));

  for (genvar g = 0; g < NREG; g++) begin : g_hold
    // R11
    untouched_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_idx == IDXW'(g)) |=> $stable(regs[g]));
  end
endmodule

// File: tb/sim_nested_regfile.sv
module sim_nested_regfile;
  typedef struct packed {
    int          wen;
    int          widx;
    int          wsz;
    int          whi;
    int          wext;
    int          wsrc;
    logic [63:0] wdat;
    int          ridx;
    int          rsz;
    int          rhi;
    logic [63:0] exp;
    int          eerr;
    int          req;
  } vec_t;

  localparam int NV = 25;
  // Requirement tags exercised by the table: R2 R3 R4 R5 R6 R7 R8 R9 R11
  localparam vec_t VT [NV] = '{
    '{1, 0, 3, 0, 0, 0, 64'h1122334455667788, 0, 3, 0, 64'h1122334455667788, 0, 2},
    '{0, 0, 0, 0, 0, 0, 64'h0, 0, 0, 0, 64'h88, 0, 3},
    '{0, 0, 0, 0, 0, 0, 64'h0, 0, 1, 0, 64'h7788, 0, 3},
    '{0, 0, 0, 0, 0, 0, 64'h0, 0, 2, 0, 64'h55667788, 0, 3},
    '{0, 0, 0, 0, 0, 0, 64'h0, 0, 0, 1, 64'h77, 0, 4},
    '{1, 0, 0, 1, 0, 0, 64'hAB, 0, 3, 0, 64'h112233445566AB88, 0, 4},
    '{1, 0, 1, 0, 0, 0, 64'hFFFFBEEF, 0, 3, 0, 64'h112233445566BEEF, 0, 6},
    '{1, 0, 2, 0, 0, 0, 64'hDEADDEADCAFEF00D, 0, 3, 0, 64'h00000000CAFEF00D, 0, 5},
    '{1, 5, 3, 0, 0, 0, 64'hFFFFFFFFFFFFFFFF, 5, 3, 0, 64'hFFFFFFFFFFFFFFFF, 0, 2},
    '{1, 5, 0, 1, 0, 0, 64'h12, 5, 3, 0, 64'hFFFFFFFFFFFFFF12, 0, 4},
    '{0, 0, 0, 0, 0, 0, 64'h0, 5, 0, 1, 64'h12, 0, 4},
    '{1, 5, 1, 0, 1, 0, 64'h80, 5, 3, 0, 64'hFFFFFFFFFFFF0080, 0, 7},
    '{1, 5, 1, 0, 2, 0, 64'h80, 5, 3, 0, 64'hFFFFFFFFFFFFFF80, 0, 8},
    '{1, 6, 3, 0, 0, 0, 64'hAAAAAAAAAAAAAAAA, 6, 3, 0, 64'hAAAAAAAAAAAAAAAA, 0, 2},
    '{1, 6, 2, 0, 2, 1, 64'h8001, 6, 3, 0, 64'h00000000FFFF8001, 0, 8},
    '{1, 6, 3, 0, 2, 2, 64'h80000000, 6, 3, 0, 64'hFFFFFFFF80000000, 0, 8},
    '{1, 7, 3, 0, 1, 0, 64'hFFFFFFFFFFFFFFF0, 7, 3, 0, 64'hF0, 0, 7},
    '{1, 7, 3, 0, 2, 0, 64'h7F, 7, 3, 0, 64'h7F, 0, 8},
    '{1, 7, 3, 0, 1, 2, 64'h1, 7, 3, 0, 64'h7F, 1, 9},
    '{1, 7, 1, 0, 2, 1, 64'hFFFF, 7, 3, 0, 64'h7F, 1, 9},
    '{1, 7, 3, 0, 3, 0, 64'h5, 7, 3, 0, 64'h7F, 1, 9},
    '{1, 7, 2, 0, 1, 0, 64'hC3, 7, 3, 0, 64'hC3, 0, 7},
    '{0, 7, 3, 0, 0, 0, 64'hDEAD, 7, 3, 0, 64'hC3, 0, 11},
    '{1, 15, 3, 0, 2, 1, 64'h8000, 15, 3, 0, 64'hFFFFFFFFFFFF8000, 0, 8},
    '{0, 0, 0, 0, 0, 0, 64'h0, 15, 2, 0, 64'hFFFF8000, 0, 3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_hi = 1'b0, rd0_hi = 1'b0, rd1_hi = 1'b0;
  logic [3:0]  wr_idx = '0, rd0_idx = '0, rd1_idx = '0;
  logic [1:0]  wr_size = '0, wr_ext = '0, wr_src_size = '0, rd0_size = '0, rd1_size = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0_data, rd1_data;
  logic        ext_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nested_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_hi(wr_hi), .wr_ext(wr_ext), .wr_src_size(wr_src_size), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi), .rd1_data(rd1_data),
    .ext_err(ext_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: every register reads zero after reset
    rd0_size = 2'd3;
    for (int i = 0; i < 16; i++) begin
      rd0_idx = 4'(i);
      #1 chk("R1 reset reg", rd0_data, 64'h0);
    end
    chk("R1 reset err", {63'b0, ext_err}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en       = VT[k].wen[0];
      wr_idx      = VT[k].widx[3:0];
      wr_size     = VT[k].wsz[1:0];
      wr_hi       = VT[k].whi[0];
      wr_ext      = VT[k].wext[1:0];
      wr_src_size = VT[k].wsrc[1:0];
      wr_data     = VT[k].wdat;
      @(posedge clk);
      @(negedge clk);
      wr_en    = 1'b0;
      rd0_idx  = VT[k].ridx[3:0];
      rd0_size = VT[k].rsz[1:0];
      rd0_hi   = VT[k].rhi[0];
      #1;
      chk($sformatf("R%0d data vec %0d", VT[k].req, k), rd0_data, VT[k].exp);
      chk($sformatf("R%0d err vec %0d", VT[k].req, k), {63'b0, ext_err}, {63'b0, VT[k].eerr[0]});
    end

    // R10: same-cycle read of the write target returns the old word
    @(negedge clk);
    rd0_idx = 4'd0; rd0_size = 2'd3; rd0_hi = 1'b0;
    rd1_idx = 4'd9; rd1_size = 2'd3; rd1_hi = 1'b0;
    wr_en = 1'b1; wr_idx = 4'd9; wr_size = 2'd3; wr_ext = 2'd0; wr_hi = 1'b0;
    wr_data = 64'h0123456789ABCDEF;
    #1 chk("R10 old value before edge", rd1_data, 64'h0);
    // R2: the other port reads a different register at the same time
    chk("R2 port0 concurrent", rd0_data, 64'h00000000CAFEF00D);
    @(posedge clk);
    @(negedge clk) wr_en = 1'b0;
    #1 chk("R10 new value after edge", rd1_data, 64'h0123456789ABCDEF);
    chk("R2 port0 unchanged", rd0_data, 64'h00000000CAFEF00D);

    // R1: reset in mid-run clears written registers
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    rd0_idx = 4'd6; rd1_idx = 4'd15;
    #1 chk("R1 mid reset r6", rd0_data, 64'h0);
    chk("R1 mid reset r15", rd1_data, 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule